// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital half of a two-slope integrating converter. It drives a 2-bit phase code to an external analog front end and reads back one comparator bit. Between conversions it holds the front end in auto-zero. When a start request arrives it runs a fixed integration period of 2^CNT_W clocks on the unknown input, then switches to reference deintegration and counts clocks until the comparator changes level.

The sign of the result comes from the comparator level at the end of integration. The magnitude is the deintegration count. If the comparator never changes within a window of twice the integration period, the block reports overrange with a saturated magnitude. After each conversion it drives the zero code until the comparator reports that the integrator has returned to zero, and then it goes back to auto-zero.

A result appears as a sign, a magnitude and an overrange bit, with a one-cycle valid strobe. The integrate and deintegrate codes are parameters, so the block can be used with a front end that maps those two phases the other way round.

Top module: `dsadc_seq`

## Requirements
- R1: A synchronous active-high reset puts the phase code at 01 (auto-zero), drives the valid strobe low, and clears the sign, magnitude and overrange outputs to 0.
- R2: In auto-zero without a start request, the phase code stays at 01 and the valid strobe stays low, whatever level the comparator has.
- R3: A start request sampled in auto-zero switches the phase code to INT_CODE (default 10) on the next clock. Integration then lasts exactly 2^CNT_W clock cycles before the code changes to DEINT_CODE (default 11).
- R4: The sign output is the inverse of the comparator level sampled in the last integration cycle: 0 when the comparator is high (positive input) and 1 when it is low. Comparator levels earlier in integration have no effect.
- R5: Deintegration ends at the first clock at which the comparator differs from the latched level. The magnitude is the number of deintegration cycles that came before that clock, so a change in the first deintegration cycle gives 0.
- R6: The deintegration window is 2^(CNT_W+1) cycles. A change in the last cycle gives magnitude 2^(CNT_W+1)-1 with overrange 0. No change in the window gives overrange 1 and a magnitude of all ones.
- R7: The valid strobe is high for exactly one cycle, the first cycle of the zero phase (code 00). Sign, magnitude and overrange hold their values until the next strobe.
- R8: The zero phase holds code 00 while the comparator is low. The cycle after the comparator is sampled high, the code returns to 01.
- R9: A start request during integration, deintegration or the zero phase has no effect on the phase sequence or on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Conversion request, accepted only in auto-zero |
| cmp_i | input | 1 | Comparator output from the front end |
| phase_o | output | 2 | Phase code: 00 zero, 01 auto-zero, INT_CODE, DEINT_CODE |
| valid_o | output | 1 | One-cycle result strobe |
| sign_o | output | 1 | Result sign, 1 means negative input |
| mag_o | output | CNT_W+1 | Deintegration count |
| ovr_o | output | 1 | Overrange flag for the held result |

## Verification
The assertions check the legality of the phase sequence on every cycle: auto-zero holds unless a start arrives, integration runs for exactly 2^CNT_W cycles, deintegration never goes past its window, the zero phase exits only on a high comparator, and the strobe is a single pulse tied to entry into the zero phase. They also check that an overranged result is saturated and that the held result does not change between strobes. Whether the magnitude and sign match the moment the comparator changed, and the level it had at the end of integration, can only be shown by the bench. The bench drives known comparator waveforms, including toggling before the last integration cycle, a change in the first and in the last deintegration cycle, a window with no change at all, and stray start requests.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;

   typedef enum logic [1:0] {
      ST_AZ    = 2'd0,
      ST_INT   = 2'd1,
      ST_DEINT = 2'd2,
      ST_ZERO  = 2'd3
   } seq_state_t;

   localparam logic [1:0] CODE_ZERO = 2'b00;
   localparam logic [1:0] CODE_AZ   = 2'b01;

endpackage

// File: rtl/dsadc_cnt.sv
module dsadc_cnt #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             clr_i,
   input  logic             en_i,
   output logic [CNT_W:0]   cnt_o,
   output logic             int_end_o,
   output logic             win_end_o
);

   localparam logic [CNT_W:0] INT_LAST = {1'b0, {CNT_W{1'b1}}};

   logic [CNT_W:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst || clr_i) begin
         cnt_q <= '0;
      end else if (en_i) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign cnt_o     = cnt_q;
   assign int_end_o = (cnt_q == INT_LAST);
   assign win_end_o = &cnt_q;

endmodule

// File: rtl/dsadc_fsm.sv
module dsadc_fsm
   import dsadc_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic       start_i,
   input  logic       cmp_i,
   input  logic       int_end_i,
   input  logic       win_end_i,
   output seq_state_t state_o,
   output logic       cnt_clr_o,
   output logic       cnt_en_o,
   output logic       cap_o,
   output logic       cap_ovr_o,
   output logic       pol_o
);

   seq_state_t state_q, state_nx;
   logic       pol_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_AZ;
         pol_q   <= 1'b0;
      end else begin
         state_q <= state_nx;
         if (state_q == ST_INT && int_end_i) begin
            pol_q <= cmp_i;
         end
      end
   end

   always_comb begin
      state_nx  = state_q;
      cnt_clr_o = 1'b1;
      cnt_en_o  = 1'b0;
      cap_o     = 1'b0;
      cap_ovr_o = 1'b0;
      case (state_q)
         ST_AZ: begin
            if (start_i) state_nx = ST_INT;
         end
         ST_INT: begin
            if (int_end_i) begin
               state_nx = ST_DEINT;
            end else begin
               cnt_clr_o = 1'b0;
               cnt_en_o  = 1'b1;
            end
         end
         ST_DEINT: begin
            if (cmp_i != pol_q) begin
               cap_o    = 1'b1;
               state_nx = ST_ZERO;
            end else if (win_end_i) begin
               cap_o     = 1'b1;
               cap_ovr_o = 1'b1;
               state_nx  = ST_ZERO;
            end else begin
               cnt_clr_o = 1'b0;
               cnt_en_o  = 1'b1;
            end
         end
         ST_ZERO: begin
            if (cmp_i) state_nx = ST_AZ;
         end
         default: state_nx = ST_AZ;
      endcase
   end

   assign state_o = state_q;
   assign pol_o   = pol_q;

endmodule

// File: rtl/dsadc_result.sv
module dsadc_result #(
   parameter int MAG_W = 17
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             cap_i,
   input  logic             cap_ovr_i,
   input  logic             pol_i,
   input  logic [MAG_W-1:0] cnt_i,
   output logic             valid_o,
   output logic             sign_o,
   output logic [MAG_W-1:0] mag_o,
   output logic             ovr_o
);

   always_ff @(posedge clk) begin
      if (rst) begin
         valid_o <= 1'b0;
         sign_o  <= 1'b0;
         mag_o   <= '0;
         ovr_o   <= 1'b0;
      end else begin
         valid_o <= cap_i;
         if (cap_i) begin
            sign_o <= ~pol_i;
            ovr_o  <= cap_ovr_i;
            mag_o  <= cap_ovr_i ? {MAG_W{1'b1}} : cnt_i;
         end
      end
   end

endmodule

// File: rtl/dsadc_phase_enc.sv
module dsadc_phase_enc
   import dsadc_pkg::*;
#(
   parameter logic [1:0] INT_CODE   = 2'b10,
   parameter logic [1:0] DEINT_CODE = 2'b11
) (
   input  seq_state_t state_i,
   output logic [1:0] phase_o
);

   generate
      if (INT_CODE == CODE_ZERO || INT_CODE == CODE_AZ) begin : g_bad_int
         $error("INT_CODE collides with a fixed phase code");
      end
      if (DEINT_CODE == CODE_ZERO || DEINT_CODE == CODE_AZ
          || DEINT_CODE == INT_CODE) begin : g_bad_deint
         $error("DEINT_CODE collides with another phase code");
      end
   endgenerate

   always_comb begin
      case (state_i)
         ST_AZ:    phase_o = CODE_AZ;
         ST_INT:   phase_o = INT_CODE;
         ST_DEINT: phase_o = DEINT_CODE;
         default:  phase_o = CODE_ZERO;
      endcase
   end

endmodule

// File: rtl/dsadc_seq.sv
module dsadc_seq
   import dsadc_pkg::*;
#(
   parameter int         CNT_W      = 16,
   parameter logic [1:0] INT_CODE   = 2'b10,
   parameter logic [1:0] DEINT_CODE = 2'b11,
   localparam int        MAG_W      = CNT_W + 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start_i,
   input  logic             cmp_i,
   output logic [1:0]       phase_o,
   output logic             valid_o,
   output logic             sign_o,
   output logic [MAG_W-1:0] mag_o,
   output logic             ovr_o
);

   generate
      if (CNT_W < 2 || CNT_W > 30) begin : g_bad_width
         $error("CNT_W must lie between 2 and 30");
      end
   endgenerate

   seq_state_t       state;
   logic             cnt_clr, cnt_en, int_end, win_end;
   logic             cap, cap_ovr, pol;
   logic [MAG_W-1:0] cnt;

   dsadc_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk       (clk),
      .rst       (rst),
      .clr_i     (cnt_clr),
      .en_i      (cnt_en),
      .cnt_o     (cnt),
      .int_end_o (int_end),
      .win_end_o (win_end)
   );

   dsadc_fsm u_fsm (
      .clk       (clk),
      .rst       (rst),
      .start_i   (start_i),
      .cmp_i     (cmp_i),
      .int_end_i (int_end),
      .win_end_i (win_end),
      .state_o   (state),
      .cnt_clr_o (cnt_clr),
      .cnt_en_o  (cnt_en),
      .cap_o     (cap),
      .cap_ovr_o (cap_ovr),
      .pol_o     (pol)
   );

   dsadc_result #(.MAG_W(MAG_W)) u_res (
      .clk       (clk),
      .rst       (rst),
      .cap_i     (cap),
      .cap_ovr_i (cap_ovr),
      .pol_i     (pol),
      .cnt_i     (cnt),
      .valid_o   (valid_o),
      .sign_o    (sign_o),
      .mag_o     (mag_o),
      .ovr_o     (ovr_o)
   );

   dsadc_phase_enc #(.INT_CODE(INT_CODE), .DEINT_CODE(DEINT_CODE)) u_enc (
      .state_i (state),
      .phase_o (phase_o)
   );

endmodule

// File: rtl/dsadc_seq_chk.sv
module dsadc_seq_chk
   import dsadc_pkg::*;
#(
   parameter int         CNT_W      = 16,
   parameter logic [1:0] INT_CODE   = 2'b10,
   parameter logic [1:0] DEINT_CODE = 2'b11
) (
   input logic             clk,
   input logic             rst,
   input logic             start_i,
   input logic             cmp_i,
   input logic [1:0]       phase_o,
   input logic             valid_o,
   input logic             sign_o,
   input logic [CNT_W:0]   mag_o,
   input logic             ovr_o
);

   localparam logic [CNT_W+1:0] INT_LEN = {2'b01, {CNT_W{1'b0}}};
   localparam logic [CNT_W+1:0] WIN_LEN = {2'b10, {CNT_W{1'b0}}};

   logic [CNT_W+1:0] int_run, dein_run;

   always_ff @(posedge clk) begin
      if (rst) begin
         int_run  <= '0;
         dein_run <= '0;
      end else begin
         int_run  <= (phase_o == INT_CODE)   ? int_run + 1'b1  : '0;
         dein_run <= (phase_o == DEINT_CODE) ? dein_run + 1'b1 : '0;
      end
   end

   a_r2_az_hold: assert property (@(posedge clk) disable iff (rst)
      (phase_o == CODE_AZ && !start_i) |=> (phase_o == CODE_AZ && !valid_o));

   a_r3_az_start: assert property (@(posedge clk) disable iff (rst)
      (phase_o == CODE_AZ && start_i) |=> (phase_o == INT_CODE));

   a_r3_int_bound: assert property (@(posedge clk) disable iff (rst)
      (phase_o == INT_CODE) |-> (int_run < INT_LEN));

   a_r3_int_len: assert property (@(posedge clk) disable iff (rst)
      (phase_o == DEINT_CODE && int_run != '0) |-> (int_run == INT_LEN));

   a_r9_int_next: assert property (@(posedge clk) disable iff (rst)
      (phase_o == INT_CODE) |=> (phase_o == INT_CODE || phase_o == DEINT_CODE));

   a_r6_window: assert property (@(posedge clk) disable iff (rst)
      (phase_o == DEINT_CODE) |-> (dein_run < WIN_LEN));

   a_r6_ovr_sat: assert property (@(posedge clk) disable iff (rst)
      (valid_o && ovr_o) |-> (&mag_o));

   a_r7_valid_zero: assert property (@(posedge clk) disable iff (rst)
      valid_o |-> (phase_o == CODE_ZERO));

   a_r7_valid_pulse: assert property (@(posedge clk) disable iff (rst)
      valid_o |=> !valid_o);

   a_r7_entry: assert property (@(posedge clk) disable iff (rst)
      (phase_o == DEINT_CODE) |=> ((phase_o == CODE_ZERO) == valid_o));

   a_r7_hold: assert property (@(posedge clk) disable iff (rst)
      !valid_o |-> $stable({sign_o, mag_o, ovr_o}));

   a_r8_zero_hold: assert property (@(posedge clk) disable iff (rst)
      (phase_o == CODE_ZERO && !cmp_i) |=> (phase_o == CODE_ZERO));

   a_r8_zero_exit: assert property (@(posedge clk) disable iff (rst)
      (phase_o == CODE_ZERO && cmp_i) |=> (phase_o == CODE_AZ));

endmodule

bind dsadc_seq dsadc_seq_chk #(
   .CNT_W      (CNT_W),
   .INT_CODE   (INT_CODE),
   .DEINT_CODE (DEINT_CODE)
) u_chk (
   .clk     (clk),
   .rst     (rst),
   .start_i (start_i),
   .cmp_i   (cmp_i),
   .phase_o (phase_o),
   .valid_o (valid_o),
   .sign_o  (sign_o),
   .mag_o   (mag_o),
   .ovr_o   (ovr_o)
);

// File: tb/dsadc_seq_tb_top.sv
module dsadc_seq_tb_top;

   localparam int W     = 4;
   localparam int N     = 1 << W;
   localparam int WIN   = 2 * N;
   localparam int MAG_W = W + 1;

   typedef struct packed {
      logic             sign;
      logic             ovr;
      logic [MAG_W-1:0] mag;
   } exp_t;

   logic             clk = 1'b0;
   logic             rst = 1'b1;
   logic             start_i = 1'b0;
   logic             cmp_i = 1'b0;
   logic [1:0]       phase_o;
   logic             valid_o;
   logic             sign_o;
   logic [MAG_W-1:0] mag_o;
   logic             ovr_o;

   int   checks = 0;
   int   errors = 0;
   bit   done = 1'b0;
   exp_t sb_q[$];
   exp_t mon_e;
   exp_t last_e;

   always #2.5 clk = ~clk;

   dsadc_seq #(.CNT_W(W)) dut_i (
      .clk     (clk),
      .rst     (rst),
      .start_i (start_i),
      .cmp_i   (cmp_i),
      .phase_o (phase_o),
      .valid_o (valid_o),
      .sign_o  (sign_o),
      .mag_o   (mag_o),
      .ovr_o   (ovr_o)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // Monitor: pops the scoreboard on every strobe (R5, R6, R4)
   always @(negedge clk) begin
      if (!rst && valid_o) begin
         if (sb_q.size() == 0) begin
            chk(1'b0, "R7", "strobe with no expected result", 1, 0);
         end else begin
            mon_e = sb_q.pop_front();
            chk(sign_o == mon_e.sign, "R4", "sign", int'(sign_o), int'(mon_e.sign));
            chk(mag_o == mon_e.mag, "R5", "magnitude", int'(mag_o), int'(mon_e.mag));
            chk(ovr_o == mon_e.ovr, "R6", "overrange", int'(ovr_o), int'(mon_e.ovr));
         end
      end
   end

   // Driver: one conversion. k < 0 means the comparator never changes.
   task automatic convert(input bit pos, input int k, input bit stray, input int hold);
      int   n;
      int   j;
      exp_t e;
      @(negedge clk);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      chk(phase_o == 2'b10, "R3", "integrate code after start", int'(phase_o), 2);
      n = 0;
      while (phase_o == 2'b10 && n <= N + 2) begin
         n++;
         // earlier levels alternate; only the last cycle sets the sign (R4)
         cmp_i   = (n == N) ? pos : ((n % 2) == 1 ? ~pos : pos);
         start_i = stray && (n == 3);
         @(negedge clk);
      end
      start_i = 1'b0;
      chk(n == N, "R3", "integration length", n, N);
      chk(phase_o == 2'b11, "R3", "deintegrate code", int'(phase_o), 3);
      e.sign = ~pos;
      if (k >= 0 && k < WIN) begin
         e.ovr = 1'b0;
         e.mag = MAG_W'(k);
      end else begin
         e.ovr = 1'b1;
         e.mag = '1;
      end
      sb_q.push_back(e);
      last_e = e;
      j = 0;
      while (phase_o == 2'b11 && j <= WIN + 2) begin
         cmp_i   = (k >= 0 && j >= k) ? ~pos : pos;
         start_i = stray && (j == 1);
         @(negedge clk);
         j++;
      end
      start_i = 1'b0;
      chk(phase_o == 2'b00, "R7", "zero code after deintegration", int'(phase_o), 0);
      chk(valid_o == 1'b1, "R7", "strobe on zero entry", int'(valid_o), 1);
      cmp_i = 1'b0;
      for (int h = 0; h < hold; h++) begin
         start_i = stray && (h == 0);
         @(negedge clk);
         start_i = 1'b0;
         chk(phase_o == 2'b00, "R8", "zero held while comparator low", int'(phase_o), 0);
         if (h == 0) begin
            chk(valid_o == 1'b0, "R7", "strobe lasts one cycle", int'(valid_o), 0);
            chk(mag_o == last_e.mag, "R7", "magnitude held", int'(mag_o), int'(last_e.mag));
         end
      end
      cmp_i = 1'b1;
      @(negedge clk);
      chk(phase_o == 2'b01, "R8", "auto-zero after comparator high", int'(phase_o), 1);
      if (stray) begin
         chk(valid_o == 1'b0, "R9", "no extra strobe from stray start", int'(valid_o), 0);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(phase_o == 2'b01, "R1", "reset phase", int'(phase_o), 1);
      chk(valid_o == 1'b0, "R1", "reset strobe", int'(valid_o), 0);
      chk({sign_o, mag_o, ovr_o} == '0, "R1", "reset result",
          int'({sign_o, mag_o, ovr_o}), 0);
      rst = 1'b0;

      // R2: comparator activity in auto-zero without a start
      for (int i = 0; i < 6; i++) begin
         cmp_i = ~cmp_i;
         @(negedge clk);
         chk(phase_o == 2'b01 && !valid_o, "R2", "auto-zero hold",
             int'(phase_o), 1);
      end

      convert(1'b1, 5, 1'b0, 2);         // R5 positive input
      convert(1'b0, 0, 1'b0, 3);         // R5 change in first cycle, negative
      convert(1'b1, WIN - 1, 1'b0, 1);   // R6 change in last window cycle
      convert(1'b0, -1, 1'b0, 2);        // R6 no change: overrange
      convert(1'b1, 20, 1'b1, 3);        // R9 stray starts everywhere
      convert(1'b0, 1, 1'b0, 0);         // R8 comparator high at zero entry

      repeat (4) @(negedge clk);
      chk(sb_q.size() == 0, "R7", "all expected results seen", sb_q.size(), 0);
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule